// File: doc/BRIEF.md
# Snooping MSI Coherence Controller

This block tracks the coherence status of every line in a small direct-mapped private cache that sits on a shared snooping bus. Each line is Invalid, Shared (readable only) or Exclusive (readable and writable, possibly dirty). The local CPU presents read and write requests by address. The block answers hits at once. For misses it requests the bus, waits for a grant, and then places a read miss or write miss on the bus. When a dirty Exclusive line is displaced by a conflicting address, it places a write-back first.

At the same time the block watches the misses that other caches drive onto the bus. A snooped write miss to a block held here invalidates the local copy. A snooped read miss to a block held Exclusive downgrades the copy to Shared. When the local copy was Exclusive, both of these snoops force a write-back. Snoops always win over the local CPU in the same cycle. Data storage, memory and bus arbitration are outside the block.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line reads as Invalid (state code 00), bus_req is low and no bus strobe is issued.
- R2: A CPU read to a line that is Invalid, or whose tag differs, completes with cpu_hit low. One cycle after completion the block drives a read miss (bus_cmd 01) with the request address.
- R3: A CPU write that is not an Exclusive hit completes with cpu_hit low. One cycle after completion it drives a write miss (bus_cmd 10) and the line becomes Exclusive (state 10). This covers upgrades of Shared lines.
- R4: A CPU read to a Shared or Exclusive line with a matching tag, or a CPU write to an Exclusive line with a matching tag, raises cpu_ready with cpu_hit in the request cycle. It issues no bus_req and no strobe.
- R5: A CPU read that conflicts with a Shared line issues only a read miss (no write-back). The line becomes Shared (state 01) under the new tag.
- R6: A CPU miss that conflicts with an Exclusive line first issues a write-back, in the cycle after the grant. The write-back raises wb_valid with bus_cmd 11 and the old block address. A miss for the new address follows in the next cycle. A read leaves the line Shared and a write leaves it Exclusive.
- R7: A snooped write miss (snp_cmd 10) to a matching Shared or Exclusive line makes it Invalid. When the line was Exclusive, the snoop also issues a write-back of that block.
- R8: A snooped read miss (snp_cmd 01) to a matching Exclusive line issues a write-back and makes the line Shared. For a matching Shared line it has no effect.
- R9: A snoop whose tag differs from the stored tag has no effect on the line state or the bus. The same holds for a snooped write-back (snp_cmd 11).
- R10: When snp_valid is high, the snoop is handled and cpu_ready stays low in that cycle. Any grant in that cycle is ignored. The CPU request is then served against the updated line state.
- R11: While a miss waits for its grant, cpu_ready is low and bus_req is high. bus_req stays high from the cycle after the miss is seen until the request completes, and falls one cycle after completion.
- R12: Every bus strobe lasts one cycle and carries a non-zero command. wb_valid is only ever raised together with bus_cmd 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU request pending, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | CPU block address (low bits index, high bits tag) |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_hit | output | 1 | Completion was a hit |
| cpu_line_st | output | 2 | State of cpu_addr's block: 00 Invalid, 01 Shared, 10 Exclusive |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd_valid | output | 1 | One-cycle bus transaction strobe |
| bus_cmd | output | 2 | 01 read miss, 10 write miss, 11 write-back |
| bus_addr | output | ADDR_W | Block address of the transaction |
| wb_valid | output | 1 | Write-back strobe |
| snp_valid | input | 1 | Snooped transaction valid |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped block address |

## Verification
A snoop and a local CPU step can fall in the same cycle, and the snoop must win. The bench provokes this twice. In the first case, a read hit to an Exclusive line meets a snooped read miss to the same block. In the second, an upgrade write that is waiting for the bus meets a snooped write miss together with the grant. In each case it checks three things: cpu_ready is low in the clash cycle, only the snoop's effect (write-back or invalidation) appears, and the CPU request then completes in the following cycle against the downgraded state (a Shared hit in the first case, a write miss in the second).

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl #(
  parameter int ADDR_W = 8,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic              cpu_hit,
  output logic [1:0]        cpu_line_st,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_cmd_valid,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              wb_valid,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  localparam logic [1:0] ST_I = 2'b00, ST_S = 2'b01, ST_E = 2'b10;
  localparam logic [1:0] CMD_RD = 2'b01, CMD_WR = 2'b10, CMD_WB = 2'b11;

  typedef enum logic [1:0] {F_IDLE, F_ARB, F_MISS} fsm_t;

  fsm_t             fsm;
  logic [1:0]       st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];

  logic [IDX_W-1:0] c_idx, s_idx;
  logic [TAG_W-1:0] c_tag, s_tag;
  logic [1:0]       c_st, s_st;
  logic             c_match, s_match, c_hit, c_wb, miss_go;

  assign c_idx   = cpu_addr[IDX_W-1:0];
  assign c_tag   = cpu_addr[ADDR_W-1:IDX_W];
  assign c_st    = st_q[c_idx];
  assign c_match = (tag_q[c_idx] == c_tag) && (c_st != ST_I);
  assign c_hit   = c_match && (!cpu_we || c_st == ST_E);
  assign c_wb    = (c_st == ST_E) && !c_match;

  assign s_idx   = snp_addr[IDX_W-1:0];
  assign s_tag   = snp_addr[ADDR_W-1:IDX_W];
  assign s_st    = st_q[s_idx];
  assign s_match = (tag_q[s_idx] == s_tag) && (s_st != ST_I);

  assign miss_go = !snp_valid && ((fsm == F_ARB && bus_gnt && !c_wb) || fsm == F_MISS);

  assign cpu_hit     = !snp_valid && fsm == F_IDLE && cpu_req && c_hit;
  assign cpu_ready   = cpu_hit || miss_go;
  assign cpu_line_st = c_match ? c_st : ST_I;
  assign bus_req     = (fsm != F_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm           <= F_IDLE;
      bus_cmd_valid <= 1'b0;
      bus_cmd       <= 2'b00;
      bus_addr      <= '0;
      wb_valid      <= 1'b0;
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
      end
    end else begin
      bus_cmd_valid <= 1'b0;
      wb_valid      <= 1'b0;
      if (snp_valid) begin
        if (s_match && snp_cmd != CMD_WB) begin
          if (s_st == ST_E) begin
            bus_cmd_valid <= 1'b1;
            wb_valid      <= 1'b1;
            bus_cmd       <= CMD_WB;
            bus_addr      <= snp_addr;
          end
          if (snp_cmd == CMD_WR)
            st_q[s_idx] <= ST_I;
          else if (s_st == ST_E)
            st_q[s_idx] <= ST_S;
        end
      end else begin
        case (fsm)
          F_IDLE: if (cpu_req && !c_hit) fsm <= F_ARB;
          F_ARB: if (bus_gnt && c_wb) begin
            bus_cmd_valid <= 1'b1;
            wb_valid      <= 1'b1;
            bus_cmd       <= CMD_WB;
            bus_addr      <= {tag_q[c_idx], c_idx};
            st_q[c_idx]   <= ST_I;
            fsm           <= F_MISS;
          end
          default: ;
        endcase
        if (miss_go) begin
          bus_cmd_valid <= 1'b1;
          bus_cmd       <= cpu_we ? CMD_WR : CMD_RD;
          bus_addr      <= cpu_addr;
          tag_q[c_idx]  <= c_tag;
          st_q[c_idx]   <= cpu_we ? ST_E : ST_S;
          fsm           <= F_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_we,
  input logic       cpu_ready,
  input logic       cpu_hit,
  input logic       bus_req,
  input logic       snp_valid,
  input logic       bus_cmd_valid,
  input logic [1:0] bus_cmd,
  input logic       wb_valid
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!bus_cmd_valid && !bus_req));

  p_read_miss_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !cpu_hit && !cpu_we) |=> (bus_cmd_valid && bus_cmd == 2'b01));

  p_write_miss_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !cpu_hit && cpu_we) |=> (bus_cmd_valid && bus_cmd == 2'b10));

  p_hit_no_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> (cpu_ready && !bus_req));

  p_wb_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (bus_cmd_valid && bus_cmd == 2'b11));

  p_snoop_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_ready);

  p_stall_on_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !cpu_ready);

  p_cmd_nonzero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid |-> (bus_cmd != 2'b00));
endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_ready(cpu_ready),
  .cpu_hit(cpu_hit), .bus_req(bus_req), .snp_valid(snp_valid),
  .bus_cmd_valid(bus_cmd_valid), .bus_cmd(bus_cmd), .wb_valid(wb_valid)
);

// File: tb/msi_snoop_ctrl_bench.sv
`timescale 1ns/1ps
module msi_snoop_ctrl_bench;
  localparam int AW = 8;
  localparam logic [AW-1:0] A = 8'h11, A2 = 8'h19, B = 8'h23, B2 = 8'h2B, C = 8'h35;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0, bus_gnt = 0, snp_valid = 0;
  logic [AW-1:0] cpu_addr = '0, snp_addr = '0;
  logic [1:0] snp_cmd = '0;
  logic cpu_ready, cpu_hit, bus_req, bus_cmd_valid, wb_valid;
  logic [1:0] cpu_line_st, bus_cmd;
  logic [AW-1:0] bus_addr;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  msi_snoop_ctrl u_msi_snoop_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .cpu_line_st(cpu_line_st),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_valid(bus_cmd_valid),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr), .wb_valid(wb_valid),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic line_is(input logic [AW-1:0] addr, input logic [1:0] exp, input string req);
    cpu_addr = addr; #1;
    chk(cpu_line_st == exp, req, "line state", cpu_line_st, exp);
  endtask

  task automatic do_hit(input bit we, input logic [AW-1:0] addr);
    @(negedge clk); cpu_we = we; cpu_addr = addr; cpu_req = 1; #1;
    chk(cpu_ready && cpu_hit, "R4", "ready/hit", {cpu_ready, cpu_hit}, 3);
    chk(!bus_req, "R4", "bus_req", bus_req, 0);
    @(posedge clk); #1;
    chk(!bus_cmd_valid, "R4", "strobe on hit", bus_cmd_valid, 0);
    @(negedge clk); cpu_req = 0;
  endtask

  task automatic do_miss(input bit we, input logic [AW-1:0] addr, input bit wb,
                         input logic [AW-1:0] wbaddr, input string req);
    @(negedge clk); cpu_we = we; cpu_addr = addr; cpu_req = 1; #1;
    chk(!cpu_ready, "R11", "ready at request", cpu_ready, 0);
    @(negedge clk); #1;
    chk(bus_req, "R11", "bus_req while waiting", bus_req, 1);
    chk(!cpu_ready, "R11", "stall without grant", cpu_ready, 0);
    @(negedge clk); bus_gnt = 1; #1;
    if (wb) begin
      chk(!cpu_ready, "R6", "ready in write-back grant", cpu_ready, 0);
      @(posedge clk); #1;
      chk(wb_valid && bus_cmd_valid && bus_cmd == 2'b11, "R6", "write-back strobe",
          {wb_valid, bus_cmd_valid, bus_cmd}, 4'hF);
      chk(bus_addr == wbaddr, "R6", "write-back addr", bus_addr, wbaddr);
      @(negedge clk); #1;
    end
    chk(cpu_ready && !cpu_hit, req, "miss completion", {cpu_ready, cpu_hit}, 2);
    @(posedge clk); #1;
    chk(bus_cmd_valid && bus_cmd == (we ? 2'b10 : 2'b01), req, "miss command",
        {bus_cmd_valid, bus_cmd}, we ? 6 : 5);
    chk(bus_addr == addr && !wb_valid, req, "miss addr", bus_addr, addr);
    @(negedge clk); cpu_req = 0; bus_gnt = 0;
    @(posedge clk); #1;
    chk(!bus_cmd_valid, "R12", "strobe length", bus_cmd_valid, 0);
    chk(!bus_req, "R11", "bus_req released", bus_req, 0);
    line_is(addr, we ? 2'b10 : 2'b01, req);
  endtask

  task automatic do_snoop(input logic [1:0] cmd, input logic [AW-1:0] addr, input bit exp_wb,
                          input logic [AW-1:0] chk_addr, input logic [1:0] exp_st, input string req);
    @(negedge clk); snp_valid = 1; snp_cmd = cmd; snp_addr = addr;
    @(posedge clk); #1;
    chk(wb_valid == exp_wb && bus_cmd_valid == exp_wb, req, "snoop write-back",
        {wb_valid, bus_cmd_valid}, exp_wb ? 3 : 0);
    if (exp_wb) chk(bus_cmd == 2'b11 && bus_addr == addr, req, "snoop wb addr", bus_addr, addr);
    @(negedge clk); snp_valid = 0;
    line_is(chk_addr, exp_st, req);
  endtask

  task automatic prio_idle();
    @(negedge clk); cpu_req = 1; cpu_we = 0; cpu_addr = C;
    snp_valid = 1; snp_cmd = 2'b01; snp_addr = C; #1;
    chk(!cpu_ready, "R10", "ready during snoop (idle)", cpu_ready, 0);
    @(posedge clk); #1;
    chk(wb_valid && bus_addr == C, "R10", "snoop wb first", bus_addr, C);
    @(negedge clk); snp_valid = 0; #1;
    chk(cpu_ready && cpu_hit, "R10", "hit after downgrade", {cpu_ready, cpu_hit}, 3);
    chk(cpu_line_st == 2'b01, "R10", "downgraded state", cpu_line_st, 1);
    @(posedge clk); @(negedge clk); cpu_req = 0;
  endtask

  task automatic prio_arb();
    @(negedge clk); cpu_req = 1; cpu_we = 1; cpu_addr = A;
    @(negedge clk); #1;
    chk(bus_req, "R11", "upgrade waits", bus_req, 1);
    snp_valid = 1; snp_cmd = 2'b10; snp_addr = A; bus_gnt = 1; #1;
    chk(!cpu_ready, "R10", "grant ignored under snoop", cpu_ready, 0);
    @(posedge clk); #1;
    chk(!bus_cmd_valid, "R10", "no own command", bus_cmd_valid, 0);
    chk(cpu_line_st == 2'b00, "R10", "invalidated first", cpu_line_st, 0);
    @(negedge clk); snp_valid = 0; #1;
    chk(cpu_ready && !cpu_hit, "R10", "served after snoop", {cpu_ready, cpu_hit}, 2);
    @(posedge clk); #1;
    chk(bus_cmd_valid && bus_cmd == 2'b10 && bus_addr == A, "R10", "write miss after snoop",
        bus_cmd, 2);
    @(negedge clk); cpu_req = 0; bus_gnt = 0;
    line_is(A, 2'b10, "R10");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    chk(!bus_req && !bus_cmd_valid && !wb_valid, "R1", "quiet after reset",
        {bus_req, bus_cmd_valid, wb_valid}, 0);
    for (int i = 0; i < 8; i++) line_is(AW'(i), 2'b00, "R1");
    do_miss(0, A, 0, '0, "R2");
    do_hit(0, A);
    do_miss(0, A2, 0, '0, "R5");
    line_is(A, 2'b00, "R5");
    do_miss(1, A2, 0, '0, "R3");
    do_hit(1, A2);
    do_hit(0, A2);
    do_miss(0, A, 1, A2, "R6");
    do_miss(1, B, 0, '0, "R3");
    do_miss(1, B2, 1, B, "R6");
    do_snoop(2'b01, B, 0, B2, 2'b10, "R9");
    do_snoop(2'b11, B2, 0, B2, 2'b10, "R9");
    do_snoop(2'b10, B, 0, B2, 2'b10, "R9");
    do_snoop(2'b01, B2, 1, B2, 2'b01, "R8");
    do_snoop(2'b01, B2, 0, B2, 2'b01, "R8");
    do_snoop(2'b10, B2, 0, B2, 2'b00, "R7");
    do_miss(1, C, 0, '0, "R3");
    do_snoop(2'b10, C, 1, C, 2'b00, "R7");
    do_miss(1, C, 0, '0, "R3");
    prio_idle();
    prio_arb();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule